// File: doc/BRIEF.md
# Protected Multi-Mode Watchdog Timer

This block is a watchdog counter that advances on a slow tick enable. The tick stands in for a separate low-frequency oscillator. Software restarts the counter with a restart strobe. If the counter reaches the selected tick count without a restart, the block acts according to its mode: it raises an interrupt, it pulses a system reset, or it raises an interrupt first and issues a reset on the next time-out. The mode and the time-out are held in one 8-bit control/status register. The register has a write port and a read port.

The block guards its safety-relevant settings. Software can turn the reset enable on, and can write the interrupt enable, at any time. Turning the reset enable off, or changing the time-out, needs a two-write unlock sequence, and the second write must fall inside a short window of clock cycles. An always-on fuse input can hold the block in reset mode. A reset-flag input can hold the reset enable set. In interrupt-then-reset mode, an interrupt acknowledge drops the block back into plain reset mode, so software must re-arm the interrupt each time.

Top module: `prot_wdog`

## Requirements
- R1: After the synchronous reset, the register reads 0x08: flag, interrupt enable, change enable and prescale are 0, and reset enable is 1. `irq` and `wdt_rst` are low.
- R2: The register layout is: bit7 flag, bit6 interrupt enable, bit5 prescale[3], bit4 change enable, bit3 reset enable, bits 2..0 prescale[2:0]. Prescale code c from 0 to 9 gives a time-out of 2^(BASE_LOG2+c) ticks. Codes 10 to 15 act as code 9. Only cycles with `tick_en` high count.
- R3: `kick` clears the counter to zero. A kick wins over a tick in the same cycle, so regular kicks prevent every time-out.
- R4: The mode is set by {reset enable, interrupt enable}. 00 is stopped and takes no action. 01 sets the flag on a time-out. 10 pulses `wdt_rst` high for exactly one clock, in the cycle after the edge that completes the time-out.
- R5: In mode 11, a time-out with the flag clear sets the flag. A time-out while the flag is still set pulses `wdt_rst`. An acknowledge while the flag is set clears both flag and interrupt enable. If that acknowledge falls on the same cycle as the second time-out, the reset pulse is still issued.
- R6: `irq` is high while the flag and the effective interrupt enable are both 1. The flag is cleared by an acknowledge or by writing 1 to bit7. A time-out that sets the flag wins over a same-cycle write-1 clear. In mode 01, an acknowledge leaves the interrupt enable set.
- R7: A write with bit4=1 and bit3=1 opens a window, and bit4 reads 1 for the next 4 clocks. A write with bit4=0 in any of those 4 cycles loads reset enable and prescale, and closes the window.
- R8: Outside the window, a write cannot clear the reset enable or change the prescale. Setting the reset enable, and writing the interrupt enable, always take effect.
- R9: While `fuse_on` is high, reset enable reads and stays 1, interrupt enable reads and stays 0, and every time-out pulses `wdt_rst`.
- R10: While `rst_flag` is high, the reset enable is held at 1, even against a write made inside the window.
- R11: The counter restarts from zero after each time-out. If a new prescale is below the current count, the next tick produces a time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow-time tick enable for the counter |
| kick | input | 1 | Restart strobe, clears the counter |
| irq_ack | input | 1 | Interrupt acknowledge |
| fuse_on | input | 1 | Always-on fuse, forces reset mode |
| rst_flag | input | 1 | Reset-cause flag, holds reset enable set |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | One-clock system reset pulse |

## Verification
Several events can land on the same clock edge: a time-out together with an acknowledge, and a time-out together with a write-1 flag clear. The bench runs a behavioural model in step with the design. It uses that model's counter to find the cycle just before a time-out and drives the acknowledge or the clearing write exactly there. For the acknowledge, it expects the reset pulse and a cleared flag and enable. For the clearing write, it expects the flag to remain set. The unlock window is probed at its last allowed cycle and at the first refused cycle.

// File: rtl/prot_wdog_pkg.sv
package prot_wdog_pkg;

  localparam int unsigned CSR_W    = 8;
  localparam int unsigned PS_W     = 4;
  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_PS3  = 5;
  localparam int unsigned BIT_CE   = 4;
  localparam int unsigned BIT_RE   = 3;

  // Encoded as {reset enable, interrupt enable}
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_IRQ     = 2'b01,
    MODE_RST     = 2'b10,
    MODE_IRQ_RST = 2'b11
  } wd_mode_e;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int unsigned WIN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic commit,
  output logic win_open
);
  localparam int unsigned WIN_W = $clog2(WIN_LEN + 1);

  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (open_req) begin
      win_q <= WIN_W'(WIN_LEN);
    end else if (commit) begin
      win_q <= '0;
    end else if (win_q != '0) begin
      win_q <= win_q - WIN_W'(1);
    end
  end

  assign win_open = (win_q != '0);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import prot_wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 11,
  parameter int unsigned NUM_STEPS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            kick,
  input  logic            tick_en,
  input  logic [PS_W-1:0] ps,
  output logic            expire
);
  localparam int unsigned CNT_W   = BASE_LOG2 + NUM_STEPS - 1;
  localparam int unsigned TOP_SEL = NUM_STEPS - 1;

  logic [CNT_W-1:0] lim_m1 [NUM_STEPS];
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  sel;
  logic             due;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_lim
    localparam logic [CNT_W-1:0] LIM_M1 =
      CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    assign lim_m1[g] = LIM_M1;
  end

  always_comb begin
    sel    = (ps >= PS_W'(TOP_SEL)) ? PS_W'(TOP_SEL) : ps;
    due    = (cnt_q >= lim_m1[sel]);
    expire = run & ~kick & tick_en & due;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || kick) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= due ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
  import prot_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             irq_ack,
  input  logic             fuse_on,
  input  logic             rst_flag,
  input  logic             win_open,
  input  logic             expire,
  output logic             open_req,
  output logic             commit,
  output logic             run,
  output logic [PS_W-1:0]  ps,
  output logic [CSR_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_pulse
);
  logic            flag_q, ie_q, re_q, rstp_q;
  logic [PS_W-1:0] ps_q;
  logic            re_eff, ie_eff, ack_hit, set_flag, fire, wr_clr;
  wd_mode_e        mode;

  always_comb begin
    re_eff   = re_q | fuse_on | rst_flag;
    ie_eff   = ie_q & ~fuse_on;
    mode     = wd_mode_e'({re_eff, ie_eff});
    ack_hit  = irq_ack & flag_q;
    wr_clr   = wr_en & wr_data[BIT_FLAG];
    open_req = wr_en & wr_data[BIT_CE] & wr_data[BIT_RE];
    commit   = wr_en & ~wr_data[BIT_CE] & win_open;
    set_flag = 1'b0;
    fire     = 1'b0;
    if (expire) begin
      unique case (mode)
        MODE_IRQ:     set_flag = 1'b1;
        MODE_RST:     fire     = 1'b1;
        MODE_IRQ_RST: begin
          fire     = flag_q;
          set_flag = ~ack_hit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      re_q   <= 1'b1;
      ps_q   <= '0;
      rstp_q <= 1'b0;
    end else begin
      rstp_q <= fire;

      if (set_flag) begin
        flag_q <= 1'b1;
      end else if (ack_hit || wr_clr) begin
        flag_q <= 1'b0;
      end

      if (fuse_on) begin
        ie_q <= 1'b0;
      end else if (ack_hit && re_eff) begin
        ie_q <= 1'b0;
      end else if (wr_en) begin
        ie_q <= wr_data[BIT_IE];
      end

      if (fuse_on || rst_flag) begin
        re_q <= 1'b1;
      end else if (wr_en && wr_data[BIT_RE]) begin
        re_q <= 1'b1;
      end else if (commit) begin
        re_q <= 1'b0;
      end

      if (commit) begin
        ps_q <= {wr_data[BIT_PS3], wr_data[2:0]};
      end
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_FLAG] = flag_q;
    rd_data[BIT_IE]   = ie_eff;
    rd_data[BIT_PS3]  = ps_q[3];
    rd_data[BIT_CE]   = win_open;
    rd_data[BIT_RE]   = re_eff;
    rd_data[2:0]      = ps_q[2:0];
  end

  assign run       = re_eff | ie_eff;
  assign ps        = ps_q;
  assign irq       = flag_q & ie_eff;
  assign rst_pulse = rstp_q;

endmodule

// File: rtl/prot_wdog.sv
module prot_wdog #(
  parameter int unsigned BASE_LOG2 = 11,
  parameter int unsigned NUM_STEPS = 10,
  parameter int unsigned WIN_LEN   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       kick,
  input  logic       irq_ack,
  input  logic       fuse_on,
  input  logic       rst_flag,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wdt_rst
);
  logic       open_req, commit, win_open, run, expire;
  logic [3:0] ps;

  wdog_unlock #(.WIN_LEN(WIN_LEN)) u_unlock (
    .clk      (clk),
    .rst      (rst),
    .open_req (open_req),
    .commit   (commit),
    .win_open (win_open)
  );

  wdog_count #(.BASE_LOG2(BASE_LOG2), .NUM_STEPS(NUM_STEPS)) u_count (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .kick    (kick),
    .tick_en (tick_en),
    .ps      (ps),
    .expire  (expire)
  );

  wdog_csr u_csr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_ack   (irq_ack),
    .fuse_on   (fuse_on),
    .rst_flag  (rst_flag),
    .win_open  (win_open),
    .expire    (expire),
    .open_req  (open_req),
    .commit    (commit),
    .run       (run),
    .ps        (ps),
    .rd_data   (rd_data),
    .irq       (irq),
    .rst_pulse (wdt_rst)
  );

endmodule

// File: rtl/prot_wdog_chk.sv
module prot_wdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       unlock_wr,
  input logic       fuse_on,
  input logic       rst_flag,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       wdt_rst
);

  AST_RST_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rd_data[7] && rd_data[6])); // R6

  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (rst)
    unlock_wr |=> rd_data[4]); // R7

  AST_PS_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !rd_data[4] |=> $stable({rd_data[5], rd_data[2:0]})); // R8

  AST_RE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3] && !rd_data[4]) |=> rd_data[3]); // R8

  AST_FUSE_FORCE: assert property (@(posedge clk) disable iff (rst)
    fuse_on |-> (rd_data[3] && !rd_data[6] && !irq)); // R9

  AST_FLAG_HOLDS_RE: assert property (@(posedge clk) disable iff (rst)
    rst_flag |-> rd_data[3]); // R10

endmodule

bind prot_wdog prot_wdog_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .unlock_wr (wr_en & wr_data[4] & wr_data[3]),
  .fuse_on   (fuse_on),
  .rst_flag  (rst_flag),
  .rd_data   (rd_data),
  .irq       (irq),
  .wdt_rst   (wdt_rst)
);

// File: tb/prot_wdog_bench.sv
module prot_wdog_bench;
  localparam int B = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, kick = 1'b0, ack = 1'b0;
  logic fuse = 1'b0, rflag = 1'b0, wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic irq, wrst;

  int n_cmp = 0, n_bad = 0, cyc = 0, n_pulse = 0, last_pulse = 0;
  bit slow = 1'b0, done = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_win = 0, m_ps = 0, t_lim;
  bit m_flag = 0, m_ie = 0, m_re = 1, m_rstp = 0;
  bit t_re, t_ie, t_run, t_exp, t_ack, t_unl, t_com;

  prot_wdog #(.BASE_LOG2(B)) u_prot_wdog (
    .clk(clk), .rst(rst), .tick_en(tick), .kick(kick), .irq_ack(ack),
    .fuse_on(fuse), .rst_flag(rflag), .wr_en(wr), .wr_data(wd),
    .rd_data(rd), .irq(irq), .wdt_rst(wrst)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #1;
    tick <= slow ? ~tick : 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_win = 0; m_ps = 0;
      m_flag = 0; m_ie = 0; m_re = 1; m_rstp = 0;
    end else begin
      t_re  = m_re || fuse || rflag;
      t_ie  = m_ie && !fuse;
      t_run = t_re || t_ie;
      t_lim = 1 << (B + ((m_ps > 9) ? 9 : m_ps));
      t_exp = t_run && !kick && tick && (m_cnt >= t_lim - 1);
      t_ack = ack && m_flag;
      t_unl = wr && wd[4] && wd[3];
      t_com = wr && !wd[4] && (m_win > 0);
      m_rstp = t_exp && t_re && (!t_ie || m_flag);
      if (t_exp && t_ie && !(t_ack && t_re)) m_flag = 1;
      else if (t_ack || (wr && wd[7])) m_flag = 0;
      if (fuse) m_ie = 0;
      else if (t_ack && t_re) m_ie = 0;
      else if (wr) m_ie = wd[6];
      if (fuse || rflag) m_re = 1;
      else if (wr && wd[3]) m_re = 1;
      else if (t_com) m_re = 0;
      if (t_com) m_ps = {wd[5], wd[2:0]};
      if (t_unl) m_win = 4;
      else if (t_com) m_win = 0;
      else if (m_win > 0) m_win--;
      if (!t_run || kick) m_cnt = 0;
      else if (tick) m_cnt = t_exp ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    logic [7:0] e;
    if (!rst && !done) begin
      e = {m_flag, m_ie && !fuse, m_ps[3], m_win > 0, m_re || fuse || rflag, m_ps[2:0]};
      chk("R7 register read", rd, e);
      chk("R6 irq", irq, m_flag && m_ie && !fuse);
      chk("R4 reset pulse", wrst, m_rstp);
      if (wrst) begin n_pulse++; last_pulse = cyc; end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wrt(input logic [7:0] v);
    wr = 1'b1; wd = v; step(); wr = 1'b0; wd = 8'h00;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic sample(output logic [7:0] r, output logic i, output logic p);
    @(negedge clk); r = rd; i = irq; p = wrst;
    @(posedge clk); #1;
  endtask

  task automatic wait_pulse(output int c);
    int s = n_pulse;
    while (n_pulse == s) step();
    c = last_pulse;
  endtask

  task automatic period(output int p);
    int a, b;
    wait_pulse(a); wait_pulse(b); p = b - a;
  endtask

  function automatic logic [7:0] mk(input bit ie, input bit re, input int ps);
    return {1'b0, ie, ps[3], 1'b0, re, ps[2:0]};
  endfunction

  task automatic unlock_set(input logic [7:0] v);
    wrt(8'h18); wrt(v);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    logic [7:0] r; logic i, p; int per, n0, c1, c2;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    sample(r, i, p);
    chk("R1 reset read", r, 8'h08); chk("R1 irq idle", i, 0); chk("R1 rst idle", p, 0);

    // R2 default time-out 2^B ticks, R11 periodic restart
    period(per); chk("R2 period code 0", per, 8);
    period(per); chk("R11 restart after time-out", per, 8);

    // R3 regular kicks prevent time-outs
    n0 = n_pulse;
    for (int k = 0; k < 50; k++) begin
      kick = 1'b1; step(); kick = 1'b0; step(); step(); step();
    end
    chk("R3 kicks hold off reset", n_pulse - n0, 0);

    // R8 protected fields refuse writes outside the window
    wrt(mk(0, 0, 5)); sample(r, i, p);
    chk("R8 clear without unlock ignored", r, 8'h08);
    wrt(8'h18); repeat (4) step(); wrt(mk(0, 1, 2)); sample(r, i, p);
    chk("R8 late write ignored", r, 8'h08);

    // R7 last allowed cycle of the window
    wrt(8'h18); repeat (3) step(); wrt(mk(0, 1, 2)); sample(r, i, p);
    chk("R7 commit in window", r, 8'h0A);
    period(per); chk("R7 new prescale period", per, 32);
    wrt(8'h18); sample(r, i, p); chk("R7 CE set", r[4], 1);
    step(); step(); sample(r, i, p); chk("R7 CE last cycle", r[4], 1);
    sample(r, i, p); chk("R7 CE auto clear", r[4], 0);

    // R4 stopped mode
    unlock_set(mk(0, 0, 0)); sample(r, i, p);
    chk("R4 stopped read", r, 8'h00);
    n0 = n_pulse; repeat (100) step();
    chk("R4 stopped no reset", n_pulse - n0, 0); chk("R4 stopped no irq", irq, 0);

    // R6 interrupt mode
    wrt(mk(1, 0, 0)); repeat (12) step();
    chk("R6 irq after time-out", irq, 1); chk("R4 irq mode no reset", n_pulse - n0, 0);
    while (!(m_cnt == 7 && m_flag)) step();
    wrt(8'hC0); sample(r, i, p);
    chk("R6 set wins over clear", i, 1);
    pulse_ack(); sample(r, i, p);
    chk("R6 ack in irq mode keeps enable", r, 8'h40);

    // R5 interrupt then reset
    wrt(mk(1, 1, 0));
    while (!irq) step();
    pulse_ack(); sample(r, i, p);
    chk("R5 ack clears flag and enable", r, 8'h08);
    wrt(mk(1, 1, 0));
    while (!irq) step();
    c1 = cyc; wait_pulse(c2);
    chk("R5 reset on second time-out", c2 - c1, 8);
    while (!(m_cnt == 7 && m_flag)) step();
    pulse_ack(); sample(r, i, p);
    chk("R5 late ack still resets", p, 1);
    chk("R5 late ack clears", r, 8'h08);

    // R2 reserved code and tick gating
    unlock_set(mk(0, 1, 12)); sample(r, i, p);
    chk("R2 reserved code read", r, 8'h2C);
    period(per); chk("R2 reserved code period", per, 4096);
    unlock_set(mk(0, 1, 3)); slow = 1'b1;
    period(per); chk("R2 ticks only on enable", per, 128);
    slow = 1'b0;

    // R11 shrink below current count
    unlock_set(mk(0, 1, 5));
    kick = 1'b1; step(); kick = 1'b0;
    repeat (100) step();
    n0 = n_pulse;
    unlock_set(mk(0, 1, 0)); step(); step();
    chk("R11 shrink times out at once", n_pulse - n0, 1);

    // R9 fuse
    fuse = 1'b1; step();
    unlock_set(mk(1, 0, 0)); sample(r, i, p);
    chk("R9 fuse locks read", r, 8'h08);
    period(per); chk("R9 fuse reset period", per, 8);
    fuse = 1'b0; step(); sample(r, i, p);
    chk("R9 enable stays set after fuse", r, 8'h08);

    // R10 reset flag
    rflag = 1'b1; step();
    unlock_set(mk(0, 0, 0)); sample(r, i, p);
    chk("R10 flag holds enable", r[3], 1);
    rflag = 1'b0; step();
    unlock_set(mk(0, 0, 0)); sample(r, i, p);
    chk("R10 clear after flag drops", r, 8'h00);

    summary();
  end

endmodule